// File: doc/BRIEF.md
# Next Fetch Address Sequencer

This block owns the program counter of a 32-bit RISC core whose instructions are four bytes long and word-aligned. Each cycle it looks at the instruction fetched from the current address, together with a single equality flag supplied by the datapath comparator. From these it picks the address of the next fetch. That address is either the following word, a conditional branch target relative to the following word, or an absolute jump target that stays inside the current 256 MB region.

The instruction's top six bits are its opcode, in every format. Opcode 4 branches when the two compared registers are equal. Opcode 5 branches when they differ. Opcode 2 jumps. Opcode 3 jumps and also presents the address of the following word as a link value, with a strobe the register file uses to capture it. Every other opcode is treated as straight-line code. A stall input freezes the counter. A synchronous reset loads a parameterised start address.

Top module: `nextpc_core`

## Requirements
- R1: While `rst_i` is high at a rising edge, `pc_o` becomes `RESET_VEC` with its two low bits cleared, whatever `stall_i` and `instr_i` hold.
- R2: When not stalled and the opcode (`instr_i[31:26]`) is none of 2, 3, 4 or 5, `pc_o` advances to `pc_o + 4` at the next edge, regardless of `regs_equal_i`.
- R3: Opcode 4 with `regs_equal_i` = 1 loads `pc_o + 4 + (sign-extended instr_i[15:0] << 2)`. Offsets from -32768 to +32767 words are honoured.
- R4: Opcode 5 with `regs_equal_i` = 0 loads the same relative target as R3.
- R5: Opcode 4 with the flag at 0, or opcode 5 with the flag at 1, advances to `pc_o + 4`.
- R6: Opcode 2 loads `{(pc_o+4)[31:28], instr_i[25:0], 2'b00}`. The upper four bits come from the incremented address, so code in the last word of a region jumps into the next region.
- R7: Opcode 3 loads the R6 target. In the same cycle, before the edge, `link_valid_o` is 1 and `link_addr_o` equals `pc_o + 4`.
- R8: With `stall_i` high and `rst_i` low, `pc_o` keeps its value and `link_valid_o` is 0.
- R9: `pc_o[1:0]` is 0 in every cycle after reset.
- R10: `link_valid_o` is 0 whenever the opcode is not 3. `link_addr_o` always shows `pc_o + 4`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Hold the program counter this cycle |
| instr_i | input | 32 | Instruction fetched from `pc_o` |
| regs_equal_i | input | 1 | Datapath comparator result for the two register fields |
| pc_o | output | 32 | Current fetch address |
| link_addr_o | output | 32 | Return address, `pc_o + 4` |
| link_valid_o | output | 1 | Jump-and-link is committing this cycle |

## Verification
The link outputs are combinational from `pc_o` and `instr_i`, so the bench drives each vector on a falling edge and reads `link_valid_o` and `link_addr_o` one nanosecond later, before the rising edge. The program counter passes through one register, so each vector's new address is read one nanosecond after the following rising edge. The vectors form a chain: each vector starts from the address the previous one produced, so every wrong target also shows up as a wrong start address for the next vector. Reset is checked the same way, one edge after it is applied, including once with stall held high.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

    localparam int PC_W     = 32;
    localparam int INSTR_W  = 32;
    localparam int OPC_W    = 6;
    localparam int IMM_W    = 16;
    localparam int TGT_W    = 26;
    localparam int ALIGN_W  = 2;
    localparam int REGION_W = PC_W - TGT_W - ALIGN_W;
    localparam int SEXT_W   = PC_W - IMM_W - ALIGN_W;

    localparam logic [OPC_W-1:0] OPC_JUMP = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL  = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE  = 6'd5;

    typedef enum logic [2:0] {
        FLOW_SEQ = 3'd0,
        FLOW_BEQ = 3'd1,
        FLOW_BNE = 3'd2,
        FLOW_JMP = 3'd3,
        FLOW_JAL = 3'd4
    } flow_e;

    typedef struct packed {
        flow_e             kind;
        logic [IMM_W-1:0]  imm;
        logic [TGT_W-1:0]  tgt;
    } decoded_t;

    typedef struct packed {
        logic [PC_W-1:0] pc;
    } fetch_state_t;

endpackage

// File: rtl/nextpc_decode.sv
module nextpc_decode
    import nextpc_pkg::*;
(
    input  logic [INSTR_W-1:0] instr_i,
    output decoded_t           dec_o
);

    logic [OPC_W-1:0] opc;

    assign opc = instr_i[INSTR_W-1 -: OPC_W];

    always_comb begin
        dec_o.imm = instr_i[IMM_W-1:0];
        dec_o.tgt = instr_i[TGT_W-1:0];
        unique case (opc)
            OPC_JUMP: dec_o.kind = FLOW_JMP;
            OPC_JAL:  dec_o.kind = FLOW_JAL;
            OPC_BEQ:  dec_o.kind = FLOW_BEQ;
            OPC_BNE:  dec_o.kind = FLOW_BNE;
            default:  dec_o.kind = FLOW_SEQ;
        endcase
    end

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
    import nextpc_pkg::*;
(
    input  logic [PC_W-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [TGT_W-1:0] tgt_i,
    output logic [PC_W-1:0]  seq_o,
    output logic [PC_W-1:0]  br_o,
    output logic [PC_W-1:0]  jmp_o
);

    localparam logic [PC_W-1:0] STEP = PC_W'(1) << ALIGN_W;

    logic [PC_W-1:0] offset;

    assign seq_o  = pc_i + STEP;
    assign offset = {{SEXT_W{imm_i[IMM_W-1]}}, imm_i, {ALIGN_W{1'b0}}};
    assign br_o   = seq_o + offset;

    generate
        if (REGION_W > 0) begin : g_region
            assign jmp_o = {seq_o[PC_W-1 -: REGION_W], tgt_i, {ALIGN_W{1'b0}}};
        end else begin : g_flat
            assign jmp_o = {tgt_i[PC_W-ALIGN_W-1:0], {ALIGN_W{1'b0}}};
        end
    endgenerate

endmodule

// File: rtl/nextpc_resolve.sv
module nextpc_resolve
    import nextpc_pkg::*;
(
    input  flow_e           kind_i,
    input  logic            eq_i,
    input  logic [PC_W-1:0] seq_i,
    input  logic [PC_W-1:0] br_i,
    input  logic [PC_W-1:0] jmp_i,
    output logic [PC_W-1:0] next_o,
    output logic            is_link_o
);

    logic br_taken;

    always_comb begin
        br_taken  = 1'b0;
        is_link_o = 1'b0;
        next_o    = seq_i;
        unique case (kind_i)
            FLOW_BEQ: br_taken = eq_i;
            FLOW_BNE: br_taken = ~eq_i;
            FLOW_JMP: next_o   = jmp_i;
            FLOW_JAL: begin
                next_o    = jmp_i;
                is_link_o = 1'b1;
            end
            default: ;
        endcase
        if (br_taken) begin
            next_o = br_i;
        end
    end

endmodule

// File: rtl/nextpc_core.sv
module nextpc_core
    import nextpc_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        stall_i,
    input  logic [31:0] instr_i,
    input  logic        regs_equal_i,
    output logic [31:0] pc_o,
    output logic [31:0] link_addr_o,
    output logic        link_valid_o
);

    localparam logic [PC_W-1:0] START_PC = {RESET_VEC[PC_W-1:ALIGN_W], {ALIGN_W{1'b0}}};

    fetch_state_t    st_d, st_q;
    decoded_t        dec;
    logic [PC_W-1:0] seq_pc, br_pc, jmp_pc, next_pc;
    logic            is_link;

    nextpc_decode u_decode (
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    nextpc_target u_target (
        .pc_i  (st_q.pc),
        .imm_i (dec.imm),
        .tgt_i (dec.tgt),
        .seq_o (seq_pc),
        .br_o  (br_pc),
        .jmp_o (jmp_pc)
    );

    nextpc_resolve u_resolve (
        .kind_i    (dec.kind),
        .eq_i      (regs_equal_i),
        .seq_i     (seq_pc),
        .br_i      (br_pc),
        .jmp_i     (jmp_pc),
        .next_o    (next_pc),
        .is_link_o (is_link)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.pc = START_PC;
        end else if (!stall_i) begin
            st_d.pc = next_pc;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign pc_o         = st_q.pc;
    assign link_addr_o  = seq_pc;
    assign link_valid_o = is_link & ~stall_i;

endmodule

// File: rtl/nextpc_chk.sv
module nextpc_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0040_0000
) (
    input logic        clk_i,
    input logic        rst_i,
    input logic        stall_i,
    input logic [31:0] instr_i,
    input logic        regs_equal_i,
    input logic [31:0] pc_o,
    input logic [31:0] link_addr_o,
    input logic        link_valid_o
);

    logic [5:0]  opc;
    logic [31:0] inc;
    logic [31:0] rel;
    logic        plain;

    assign opc   = instr_i[31:26];
    assign inc   = pc_o + 32'd4;
    assign rel   = inc + {{14{instr_i[15]}}, instr_i[15:0], 2'b00};
    assign plain = (opc < 6'd2) || (opc > 6'd5);

    AST_RESET_LOAD: assert property (@(posedge clk_i)
        rst_i |=> pc_o == {RESET_VEC[31:2], 2'b00}); // R1

    AST_SEQ_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && plain) |=> pc_o == $past(inc)); // R2

    AST_BEQ_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && opc == 6'd4 && regs_equal_i) |=> pc_o == $past(rel)); // R3

    AST_BNE_TAKEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && opc == 6'd5 && !regs_equal_i) |=> pc_o == $past(rel)); // R4

    AST_JUMP_REGION: assert property (@(posedge clk_i) disable iff (rst_i)
        (!stall_i && (opc == 6'd2 || opc == 6'd3)) |=> pc_o[31:28] == $past(inc[31:28])); // R6

    AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> $stable(pc_o)); // R8

    AST_PC_ALIGNED: assert property (@(posedge clk_i) disable iff (rst_i)
        pc_o[1:0] == 2'b00); // R9

    AST_LINK_ONLY_JAL: assert property (@(posedge clk_i) disable iff (rst_i)
        link_valid_o |-> (opc == 6'd3 && !stall_i)); // R10

    AST_LINK_VALUE: assert property (@(posedge clk_i) disable iff (rst_i)
        link_valid_o |-> link_addr_o == inc); // R7

endmodule

bind nextpc_core nextpc_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .stall_i      (stall_i),
    .instr_i      (instr_i),
    .regs_equal_i (regs_equal_i),
    .pc_o         (pc_o),
    .link_addr_o  (link_addr_o),
    .link_valid_o (link_valid_o)
);

// File: tb/nextpc_core_tb_top.sv
module nextpc_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        eq = 1'b0;
    logic [31:0] pc, link_addr;
    logic        link_valid;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    nextpc_core #(.RESET_VEC(32'h0040_0000)) dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .stall_i      (stall),
        .instr_i      (instr),
        .regs_equal_i (eq),
        .pc_o         (pc),
        .link_addr_o  (link_addr),
        .link_valid_o (link_valid)
    );

    typedef struct packed {
        logic [31:0] instr;
        logic        eq;
        logic        stall;
        logic [31:0] exp_pc;
        logic        exp_lv;
        logic [31:0] exp_link;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        '{32'h0000_0000, 1'b0, 1'b0, 32'h0040_0004, 1'b0, 32'h0040_0004}, // R2 opcode 0
        '{32'h1000_0003, 1'b1, 1'b0, 32'h0040_0014, 1'b0, 32'h0040_0008}, // R3 forward
        '{32'h1000_0003, 1'b0, 1'b0, 32'h0040_0018, 1'b0, 32'h0040_0018}, // R5 beq not taken
        '{32'h1400_FFFE, 1'b0, 1'b0, 32'h0040_0014, 1'b0, 32'h0040_001C}, // R4 backward
        '{32'h1400_FFFE, 1'b1, 1'b0, 32'h0040_0018, 1'b0, 32'h0040_0018}, // R5 bne not taken
        '{32'h0BFF_FFFE, 1'b0, 1'b0, 32'h0FFF_FFF8, 1'b0, 32'h0040_001C}, // R6 jump
        '{32'h0000_0000, 1'b0, 1'b1, 32'h0FFF_FFF8, 1'b0, 32'h0FFF_FFFC}, // R8 stall
        '{32'h0000_0000, 1'b1, 1'b0, 32'h0FFF_FFFC, 1'b0, 32'h0FFF_FFFC}, // R2 flag ignored
        '{32'h0C00_0010, 1'b0, 1'b0, 32'h1000_0040, 1'b1, 32'h1000_0000}, // R7 R6 region from pc+4
        '{32'h0C00_0010, 1'b0, 1'b1, 32'h1000_0040, 1'b0, 32'h1000_0044}, // R8 stalled jal
        '{32'h1800_FFFF, 1'b1, 1'b0, 32'h1000_0044, 1'b0, 32'h1000_0044}, // R2 R10 opcode 6
        '{32'h1000_8000, 1'b1, 1'b0, 32'h0FFE_0048, 1'b0, 32'h1000_0048}, // R3 most negative
        '{32'h1400_7FFF, 1'b0, 1'b0, 32'h1000_0048, 1'b0, 32'h0FFE_004C}, // R4 most positive
        '{32'h1129_FFFF, 1'b1, 1'b0, 32'h1000_0048, 1'b0, 32'h1000_004C}, // R3 self loop
        '{32'h0800_0000, 1'b0, 1'b0, 32'h1000_0000, 1'b0, 32'h1000_004C}  // R6 jump to region base
    };

    task automatic check32(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] prev;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check32("R1 reset vector", pc, 32'h0040_0000);
        prev = pc;
        for (int i = 0; i < NV; i++) begin
            instr = VEC[i].instr;
            eq    = VEC[i].eq;
            stall = VEC[i].stall;
            #1;
            check32("R7 R10 link strobe", {31'b0, link_valid}, {31'b0, VEC[i].exp_lv});
            check32("R10 link address", link_addr, VEC[i].exp_link);
            @(posedge clk);
            #1;
            check32("R2-R8 next pc", pc, VEC[i].exp_pc);
            check32("R9 alignment", {30'b0, pc[1:0]}, 32'h0);
            prev = pc;
            @(negedge clk);
        end
        // R1 reset with stall high and a jump present
        stall = 1'b1;
        instr = 32'h0800_1234;
        rst   = 1'b1;
        @(posedge clk);
        #1;
        check32("R1 reset beats stall", pc, 32'h0040_0000);
        @(negedge clk);
        rst   = 1'b0;
        stall = 1'b0;
        instr = 32'h0800_1234;
        #1;
        check32("R10 plain jump no strobe", {31'b0, link_valid}, 32'h0);
        @(posedge clk);
        #1;
        check32("R6 jump after reset", pc, 32'h0000_48D0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule